// File: doc/BRIEF.md
# Accumulator Processor with Variable-Length Instructions

A small 8-bit accumulator processor. Its registers share one internal bus: a program counter, a memory address register, an instruction register, the accumulator, an operand register, a pointer register for indirect operands, an adder/subtractor and a flag register. A hardwired control decoder forms the control word for each step from three inputs: the opcode, the current step and the zero flag. The step counter returns to zero on the last step of each instruction, so short instructions spend no idle cycles.

Each instruction is an opcode byte followed by an operand byte. Only the two no-operand forms, halt and unknown opcodes, take one byte. The external memory covers the full 8-bit address space. Addresses below 248 are read-only program storage. Addresses 248 to 255 are writable data RAM. The processor never raises its write strobe for the read-only region. A halt instruction stops all fetching until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted, acc_out, halted and mem_we are 0 and mem_addr is 0. The first instruction after reset is fetched from address 0.
- R2: Instruction lengths in clock cycles are: 0x01 load-immediate 4, 0x02 load-indirect 6, 0x03 add-indirect 7, 0x04 subtract-immediate 5, 0x05 store-direct 5, 0x06 jump-if-zero 4, 0xFF halt 3, and any other opcode 3.
- R3: Opcode 0x01 copies its operand byte into the accumulator.
- R4: Opcode 0x02 treats its operand as a pointer and loads the byte at that address into the accumulator.
- R5: Opcode 0x03 adds the byte at the address named by its operand to the accumulator, modulo 256. The carry flag takes the carry out of the addition.
- R6: Opcode 0x04 subtracts its operand byte from the accumulator, modulo 256. The carry flag is set when no borrow occurs.
- R7: The zero flag is updated only by add and subtract. It is 1 exactly when the result is 0.
- R8: Opcode 0x06 jumps to its operand address when the zero flag is 1. Otherwise execution continues at the byte after its operand.
- R9: Opcode 0x05 stores the accumulator to its operand address. It raises mem_we for one cycle, with mem_wdata equal to the accumulator, only when that address is 248 or higher. For lower addresses mem_we stays 0.
- R10: After opcode 0xFF, halted stays 1 until reset. From then on acc_out and mem_addr hold their values and mem_we stays 0.
- R11: Any opcode not listed in R2 leaves the accumulator unchanged. Fetch continues at the very next byte.
- R12: Asserting reset in the middle of an instruction clears the program counter to 0 at once. The next run starts again from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| mem_addr | output | 8 | Memory address; read data must follow it combinationally |
| mem_rdata | input | 8 | Read data from memory |
| mem_wdata | output | 8 | Write data, driven from the internal bus |
| mem_we | output | 1 | Write strobe, only ever raised for the RAM region |
| halted | output | 1 | High once a halt instruction has executed |
| acc_out | output | 8 | Accumulator contents |

## Verification
Every program in the bench ends with a halt. Halted rises on the clock edge numbered by the sum of the preceding instruction lengths plus three. Each test counts rising edges from reset release and samples halted on the following falling edge, so both the instruction lengths and the results are checked at an exact cycle. Writes are logged on falling edges, while the strobe is stable. Results that persist after a halt, or after a reset in mid-instruction, are read during the cycles that follow.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int STEP_W = 3;

  localparam logic [7:0] OP_LDA_IMM = 8'h01;
  localparam logic [7:0] OP_LDA_IND = 8'h02;
  localparam logic [7:0] OP_ADD_IND = 8'h03;
  localparam logic [7:0] OP_SUB_IMM = 8'h04;
  localparam logic [7:0] OP_STA     = 8'h05;
  localparam logic [7:0] OP_JZ      = 8'h06;
  localparam logic [7:0] OP_HLT     = 8'hFF;

  // one control word per micro-step; bus drivers are the *_out fields
  typedef struct packed {
    logic pc_out;
    logic pc_inc;
    logic pc_load;
    logic mar_in;
    logic mem_out;
    logic ir_in;
    logic a_in;
    logic a_out;
    logic b_in;
    logic x_in;
    logic x_out;
    logic alu_out;
    logic sub;
    logic flags_in;
    logic mem_wr;
    logic halt;
    logic last;
  } ctrl_t;
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         carry
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    {carry, res} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ir,
  input  logic              zf,
  output ctrl_t             cw,
  output logic              halted
);
  logic [STEP_W-1:0] step_q, step_d;
  logic              halt_q, halt_d;
  logic [7:0]        op;
  ctrl_t             dec;

  assign op = ir[7:0];

  // combinational decode: step x opcode x zero flag
  always_comb begin
    dec = '0;
    case (step_q)
      3'd0: begin dec.pc_out = 1'b1; dec.mar_in = 1'b1; end
      3'd1: begin dec.mem_out = 1'b1; dec.ir_in = 1'b1; dec.pc_inc = 1'b1; end
      3'd2: begin
        case (op)
          OP_LDA_IMM, OP_LDA_IND, OP_ADD_IND, OP_SUB_IMM, OP_STA, OP_JZ: begin
            dec.pc_out = 1'b1; dec.mar_in = 1'b1;
          end
          OP_HLT:  begin dec.halt = 1'b1; dec.last = 1'b1; end
          default: dec.last = 1'b1;
        endcase
      end
      3'd3: begin
        dec.mem_out = 1'b1;
        case (op)
          OP_LDA_IMM: begin dec.a_in = 1'b1; dec.pc_inc = 1'b1; dec.last = 1'b1; end
          OP_LDA_IND, OP_ADD_IND: begin dec.x_in = 1'b1; dec.pc_inc = 1'b1; end
          OP_SUB_IMM: begin dec.b_in = 1'b1; dec.pc_inc = 1'b1; end
          OP_STA:     begin dec.mar_in = 1'b1; dec.pc_inc = 1'b1; end
          OP_JZ: begin
            dec.pc_load = zf;
            dec.pc_inc  = ~zf;
            dec.last    = 1'b1;
          end
          default: dec.last = 1'b1;
        endcase
      end
      3'd4: begin
        case (op)
          OP_LDA_IND, OP_ADD_IND: begin dec.x_out = 1'b1; dec.mar_in = 1'b1; end
          OP_SUB_IMM: begin
            dec.alu_out = 1'b1; dec.sub = 1'b1; dec.a_in = 1'b1;
            dec.flags_in = 1'b1; dec.last = 1'b1;
          end
          OP_STA:  begin dec.a_out = 1'b1; dec.mem_wr = 1'b1; dec.last = 1'b1; end
          default: dec.last = 1'b1;
        endcase
      end
      3'd5: begin
        dec.mem_out = 1'b1;
        case (op)
          OP_LDA_IND: begin dec.a_in = 1'b1; dec.last = 1'b1; end
          OP_ADD_IND: dec.b_in = 1'b1;
          default:    dec.last = 1'b1;
        endcase
      end
      3'd6: begin
        if (op == OP_ADD_IND) begin
          dec.alu_out = 1'b1; dec.a_in = 1'b1; dec.flags_in = 1'b1;
        end
        dec.last = 1'b1;
      end
      default: dec.last = 1'b1;
    endcase
  end

  always_comb begin
    cw     = halt_q ? '0 : dec;
    step_d = step_q;
    if (!halt_q) step_d = dec.last ? '0 : step_q + STEP_W'(1);
    halt_d = halt_q | cw.halt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      halt_q <= 1'b0;
    end else begin
      step_q <= step_d;
      halt_q <= halt_d;
    end
  end

  assign halted = halt_q;

  // R10: halt persists and the decoder issues nothing afterwards
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> halt_q);
  a_r10_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> (cw == '0));
endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int RAM_BASE = 248
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             cw,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_carry,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] bval,
  output logic [DATA_W-1:0] ir,
  output logic              zf
);
  localparam logic [ADDR_W-1:0] RAM_LO = ADDR_W'(RAM_BASE);

  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d, x_q, x_d;
  logic [DATA_W-1:0] ir_q, ir_d, a_q, a_d, b_q, b_d, bus;
  logic              zf_q, zf_d, cf_q, cf_d;

  // shared bus: at most one driver per step
  always_comb begin
    bus = '0;
    if (cw.pc_out)  bus = DATA_W'(pc_q);
    if (cw.mem_out) bus = mem_rdata;
    if (cw.x_out)   bus = DATA_W'(x_q);
    if (cw.a_out)   bus = a_q;
    if (cw.alu_out) bus = alu_res;
  end

  always_comb begin
    pc_d  = pc_q;
    if (cw.pc_inc)  pc_d = pc_q + ADDR_W'(1);
    if (cw.pc_load) pc_d = bus[ADDR_W-1:0];
    mar_d = cw.mar_in ? bus[ADDR_W-1:0] : mar_q;
    x_d   = cw.x_in   ? bus[ADDR_W-1:0] : x_q;
    ir_d  = cw.ir_in  ? bus : ir_q;
    a_d   = cw.a_in   ? bus : a_q;
    b_d   = cw.b_in   ? bus : b_q;
    zf_d  = cw.flags_in ? (alu_res == '0) : zf_q;
    cf_d  = cw.flags_in ? alu_carry : cf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      x_q   <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      zf_q  <= 1'b0;
      cf_q  <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      mar_q <= mar_d;
      x_q   <= x_d;
      ir_q  <= ir_d;
      a_q   <= a_d;
      b_q   <= b_d;
      zf_q  <= zf_d;
      cf_q  <= cf_d;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = bus;
  assign mem_we    = cw.mem_wr & (mar_q >= RAM_LO);
  assign acc       = a_q;
  assign bval      = b_q;
  assign ir        = ir_q;
  assign zf        = zf_q;

  // R2: the decoder never lets two sources drive the bus at once
  a_r2_bus_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cw.pc_out, cw.mem_out, cw.x_out, cw.a_out, cw.alu_out}));
  // R5: add result and its carry
  a_r5_add_result: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.flags_in && !cw.sub) |=> (a_q == $past(a_q) + $past(b_q)));
  a_r5_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.flags_in && !cw.sub) |=> (cf_q == (a_q < $past(a_q))));
  // R6: subtract result and no-borrow carry
  a_r6_sub_result: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.flags_in && cw.sub) |=> (a_q == $past(a_q) - $past(b_q)));
  a_r6_sub_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.flags_in && cw.sub) |=> (cf_q == ($past(a_q) >= $past(b_q))));
  // R7: zero flag matches the stored result
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cw.flags_in |=> (zf_q == (a_q == '0)));
  // R8: a taken jump lands on the operand byte
  a_r8_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    cw.pc_load |=> (pc_q == $past(mem_rdata[ADDR_W-1:0])));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int RAM_BASE = 248
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted,
  output logic [DATA_W-1:0] acc_out
);
  ctrl_t             cw;
  logic [DATA_W-1:0] ir, acc, bval, alu_res;
  logic              zf, alu_carry;

  acc_cpu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ir(ir), .zf(zf), .cw(cw), .halted(halted)
  );

  acc_cpu_alu #(.W(DATA_W)) u_alu (
    .a(acc), .b(bval), .sub(cw.sub), .res(alu_res), .carry(alu_carry)
  );

  acc_cpu_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE)) u_dpath (
    .clk(clk), .rst_n(rst_n), .cw(cw), .mem_rdata(mem_rdata),
    .alu_res(alu_res), .alu_carry(alu_carry), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .acc(acc), .bval(bval),
    .ir(ir), .zf(zf)
  );

  assign acc_out = acc;

  // R10: no write strobe once halted
  a_r10_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);
endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_rdata, mem_wdata, acc_out;
  logic       mem_we, halted;
  logic [7:0] mem [256];
  int checks = 0, errors = 0;
  int wr_count = 0, rom_wr = 0;
  logic [7:0] wr_addr, wr_data;

  always #2.5 clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted), .acc_out(acc_out)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      wr_count = wr_count + 1;
      wr_addr  = mem_addr;
      wr_data  = mem_wdata;
      if (mem_addr < 8'd248) rom_wr = rom_wr + 1;
    end
  end

  initial begin
    #400000;
    errors = errors + 1;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = (i < 248) ? 8'hFF : 8'h00;
    wr_count = 0;
    rom_wr   = 0;
  endtask

  // reset, then count rising edges until halted is seen
  task automatic run_prog(input int exp_cyc, input logic [7:0] exp_acc, input string req);
    int cyc = 0;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk) rst_n = 1'b1;
    while (cyc < 500) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (halted) break;
    end
    check(cyc == exp_cyc, req, "cycles to halt", cyc, exp_cyc);
    check(acc_out == exp_acc, req, "accumulator", acc_out, exp_acc);
  endtask

  task automatic t_reset();
    clear_mem();
    rst_n = 1'b0;
    @(negedge clk);
    check(acc_out == 8'h00 && !halted && !mem_we, "R1", "reset outputs", acc_out, 0);
    check(mem_addr == 8'h00, "R1", "reset address", mem_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_addr == 8'h00, "R1", "first fetch address", mem_addr, 0);
  endtask

  task automatic t_lda_imm();
    clear_mem();
    mem[0] = 8'h01; mem[1] = 8'h2A; mem[2] = 8'hFF;
    run_prog(7, 8'h2A, "R3");
  endtask

  task automatic t_lda_ind();
    clear_mem();
    mem[0] = 8'h02; mem[1] = 8'hF8; mem[2] = 8'hFF; mem[8'hF8] = 8'h37;
    run_prog(9, 8'h37, "R4");
  endtask

  task automatic t_add_ind();
    clear_mem();
    mem[0] = 8'h01; mem[1] = 8'hC8; mem[2] = 8'h03; mem[3] = 8'hF9; mem[4] = 8'hFF;
    mem[8'hF9] = 8'h50;
    run_prog(14, 8'h18, "R5");
  endtask

  task automatic t_sub_imm();
    clear_mem();
    mem[0] = 8'h01; mem[1] = 8'h10; mem[2] = 8'h04; mem[3] = 8'h03; mem[4] = 8'hFF;
    run_prog(12, 8'h0D, "R6");
    clear_mem();
    mem[0] = 8'h01; mem[1] = 8'h02; mem[2] = 8'h04; mem[3] = 8'h05; mem[4] = 8'hFF;
    run_prog(12, 8'hFD, "R6");
  endtask

  task automatic t_jz_taken();
    // Z set by SUB, kept through LDA, so the jump is taken (R7, R8)
    clear_mem();
    mem[0] = 8'h01; mem[1] = 8'h05; mem[2] = 8'h04; mem[3] = 8'h05;
    mem[4] = 8'h01; mem[5] = 8'h09; mem[6] = 8'h06; mem[7] = 8'h0C;
    mem[8] = 8'h01; mem[9] = 8'h11; mem[10] = 8'hFF;
    mem[12] = 8'h01; mem[13] = 8'h77; mem[14] = 8'hFF;
    run_prog(24, 8'h77, "R8");
  endtask

  task automatic t_jz_not_taken();
    clear_mem();
    mem[0] = 8'h01; mem[1] = 8'h05; mem[2] = 8'h04; mem[3] = 8'h03;
    mem[4] = 8'h06; mem[5] = 8'h0C; mem[6] = 8'h01; mem[7] = 8'h11; mem[8] = 8'hFF;
    mem[12] = 8'h01; mem[13] = 8'h77; mem[14] = 8'hFF;
    run_prog(20, 8'h11, "R7");
  endtask

  task automatic t_sta_ram_and_halt();
    logic [7:0] hold_addr;
    clear_mem();
    mem[0] = 8'h01; mem[1] = 8'h5A; mem[2] = 8'h05; mem[3] = 8'hFA;
    mem[4] = 8'h01; mem[5] = 8'h00; mem[6] = 8'h02; mem[7] = 8'hFA; mem[8] = 8'hFF;
    run_prog(22, 8'h5A, "R9");
    check(wr_count == 1, "R9", "RAM write count", wr_count, 1);
    check(wr_addr == 8'hFA && wr_data == 8'h5A, "R9", "write addr/data",
          {wr_addr, wr_data}, 16'hFA5A);
    hold_addr = mem_addr;
    for (int i = 0; i < 20; i++) @(negedge clk);
    check(halted == 1'b1, "R10", "halted held", halted, 1);
    check(acc_out == 8'h5A && mem_addr == hold_addr, "R10", "state frozen",
          {acc_out, mem_addr}, {8'h5A, hold_addr});
    check(wr_count == 1, "R10", "no write after halt", wr_count, 1);
  endtask

  task automatic t_sta_rom();
    clear_mem();
    mem[0] = 8'h01; mem[1] = 8'h5A; mem[2] = 8'h05; mem[3] = 8'h20; mem[4] = 8'hFF;
    mem[8'h20] = 8'h33;
    run_prog(12, 8'h5A, "R9");
    check(rom_wr == 0 && wr_count == 0, "R9", "ROM write strobes", wr_count, 0);
    check(mem[8'h20] == 8'h33, "R9", "ROM byte kept", mem[8'h20], 8'h33);
  endtask

  task automatic t_unknown();
    clear_mem();
    mem[0] = 8'h01; mem[1] = 8'h21; mem[2] = 8'h07; mem[3] = 8'h00; mem[4] = 8'hFF;
    run_prog(13, 8'h21, "R11");
  endtask

  task automatic t_reset_mid();
    clear_mem();
    mem[0] = 8'h01; mem[1] = 8'hC8; mem[2] = 8'h03; mem[3] = 8'hF9; mem[4] = 8'hFF;
    mem[8'hF9] = 8'h50;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 6; i++) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(mem_addr == 8'h00 && acc_out == 8'h00, "R12", "async clear",
          {mem_addr, acc_out}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(mem_addr == 8'h00, "R12", "restart fetch address", mem_addr, 0);
    run_prog(14, 8'h18, "R12");
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    t_lda_imm();
    t_lda_ind();
    t_add_ind();
    t_sub_imm();
    t_jz_taken();
    t_jz_not_taken();
    t_sta_ram_and_halt();
    t_sta_rom();
    t_unknown();
    t_reset_mid();
    // R2 is covered by the cycle counts in every run above
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule